// File: doc/BRIEF.md
# Per-Bit Pattern Match Detector

This block watches an 8-bit input port and raises a sticky flag when the port shows a programmed pattern. Each bit has a three-bit condition built from its mask, transition and polarity controls. A bit can be left out, or it can match a steady low or high level, a rising edge, a falling edge, or any change. Edges are found by comparing the current value with the value registered on the previous clock. An inversion mask is applied to the raw input first, so every later stage sees the corrected data.

The per-bit results are combined by a selectable mode: disabled, AND, OR, or OR with priority. The priority mode also reports the index of the highest-numbered bit that matched. When a match is taken, the block can freeze a copy of the port data. An interrupt pulse fires either on matches only or on every change of the port. Software clears the flag.

Top module: `pattern_match_detector`

## Requirements
- R1: A bit with mask 0 and transition 0 is ignored. No value or change on it produces a match.
- R2: A bit with mask 0 and transition 1 matches on any change of its corrected value from the previous cycle, in either direction.
- R3: A bit with mask 1 and transition 0 matches its level: polarity 1 matches high and polarity 0 matches low.
- R4: A bit with mask 1 and transition 1 matches an edge against the previous cycle: polarity 1 matches a rise and polarity 0 matches a fall. No edge or change is seen on the first clock after reset.
- R5: Each bit of inv_i set to 1 inverts that input bit before matching and before capture.
- R6: mode_i encodes 0 = disabled (never matches), 1 = AND (every bit that is not ignored must hit; if all bits are ignored there is never a match) and 2 = OR (any bit hits).
- R7: mode_i = 3 matches like OR. On a match taken while the flag is clear, pri_idx_o loads the index of the highest-numbered bit that hit. In all other cases pri_idx_o holds its value.
- R8: flag_o is set on the clock after a match is present. It stays set until clr_i is sampled high. A match in the same cycle as clr_i keeps the flag set.
- R9: With latch_en_i = 1, cap_o loads the corrected data on a match taken while the flag is clear, and holds while the flag is set. With latch_en_i = 0, cap_o follows the corrected data one clock late.
- R10: irq_o pulses on the clock after a match. With match_only_i = 0 it also pulses after any change of the corrected data. With match_only_i = 1, a change that is not a match gives no pulse.
- R11: Reset drives flag_o, irq_o, cap_o and pri_idx_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Raw port input |
| inv_i | input | 8 | Per-bit input inversion |
| mask_i | input | 8 | Per-bit mask control |
| trans_i | input | 8 | Per-bit transition control |
| pol_i | input | 8 | Per-bit polarity control |
| mode_i | input | 2 | Combine mode |
| latch_en_i | input | 1 | Freeze captured data on a match |
| match_only_i | input | 1 | Interrupt on matches only |
| clr_i | input | 1 | Clear the match flag |
| flag_o | output | 1 | Sticky pattern-match flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| cap_o | output | 8 | Captured or tracked corrected data |
| pri_idx_o | output | 3 | Highest matching bit index in priority mode |

## Verification
The bench checks that a rising-edge condition does not fire on the first clock after reset. A design without a valid history bit would treat the zero reset value as the previous sample and report a false edge. It checks AND mode with every bit ignored, where a naive all-ones test would match on an empty set. It also checks a steady high input under an edge condition, which a level-confused design would match. In priority mode with several bits hitting, a lowest-index encoder would report the wrong vector. The bench also covers a clear that arrives together with a new match, which must not lose the event. Finally, it checks that captured data stays frozen while the flag is set, which a design that recaptures on every match would not do.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    CMB_OFF   = 2'd0,
    CMB_AND   = 2'd1,
    CMB_OR    = 2'd2,
    CMB_ORPRI = 2'd3
  } cmb_mode_e;
endpackage

// File: rtl/pm_bit_cell.sv
module pm_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic prev_i,
  input  logic prev_vld_i,
  input  logic mask_i,
  input  logic trans_i,
  input  logic pol_i,
  output logic hit_o,
  output logic care_o
);
  always_comb begin
    care_o = mask_i | trans_i;
    unique case ({mask_i, trans_i})
      2'b00: hit_o = 1'b0;
      2'b01: hit_o = prev_vld_i & (cur_i ^ prev_i);
      2'b10: hit_o = (cur_i == pol_i);
      default: hit_o = prev_vld_i & (pol_i ? (cur_i & ~prev_i) : (~cur_i & prev_i));
    endcase
  end

  assert_ignored_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_i && !trans_i) |-> !hit_o);
  assert_no_edge_without_history_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_i && !prev_vld_i) |-> !hit_o);
endmodule

// File: rtl/pm_combine.sv
module pm_combine
  import pm_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  hit_i,
  input  logic [W-1:0]  care_i,
  input  cmb_mode_e     mode_i,
  output logic          match_o,
  output logic [IW-1:0] pri_idx_o
);
  always_comb begin
    unique case (mode_i)
      CMB_OFF: match_o = 1'b0;
      CMB_AND: match_o = (|care_i) && ((hit_i | ~care_i) == {W{1'b1}});
      default: match_o = |hit_i;
    endcase
  end

  // highest-numbered hit wins
  always_comb begin
    pri_idx_o = '0;
    for (int i = 0; i < W; i++)
      if (hit_i[i]) pri_idx_o = IW'(i);
  end

  assert_off_never_matches_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CMB_OFF) |-> !match_o);
  assert_pri_points_at_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && mode_i == CMB_ORPRI) |-> hit_i[pri_idx_o]);
endmodule

// File: rtl/pattern_match_detector.sv
module pattern_match_detector
  import pm_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  inv_i,
  input  logic [W-1:0]  mask_i,
  input  logic [W-1:0]  trans_i,
  input  logic [W-1:0]  pol_i,
  input  logic [1:0]    mode_i,
  input  logic          latch_en_i,
  input  logic          match_only_i,
  input  logic          clr_i,
  output logic          flag_o,
  output logic          irq_o,
  output logic [W-1:0]  cap_o,
  output logic [IW-1:0] pri_idx_o
);
  logic [W-1:0]  cur, prev_q, hit, care;
  logic          prev_vld_q, match, chg, take;
  logic [IW-1:0] pri_idx;
  cmb_mode_e     mode;

  assign cur  = data_i ^ inv_i;
  assign mode = cmb_mode_e'(mode_i);
  assign chg  = prev_vld_q && (cur != prev_q);
  assign take = match && !flag_o;

  for (genvar b = 0; b < W; b++) begin : g_bit
    pm_bit_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cur_i      (cur[b]),
      .prev_i     (prev_q[b]),
      .prev_vld_i (prev_vld_q),
      .mask_i     (mask_i[b]),
      .trans_i    (trans_i[b]),
      .pol_i      (pol_i[b]),
      .hit_o      (hit[b]),
      .care_o     (care[b])
    );
  end

  pm_combine #(.W(W)) u_combine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .care_i    (care),
    .mode_i    (mode),
    .match_o   (match),
    .pri_idx_o (pri_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      flag_o     <= 1'b0;
      irq_o      <= 1'b0;
      cap_o      <= '0;
      pri_idx_o  <= '0;
    end else begin
      prev_q     <= cur;
      prev_vld_q <= 1'b1;
      flag_o     <= match | (flag_o & ~clr_i);
      irq_o      <= match | (~match_only_i & chg);
      if (!latch_en_i || take) cap_o <= cur;
      if (take && mode == CMB_ORPRI) pri_idx_o <= pri_idx;
    end
  end

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  assert_flag_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !match) |=> !flag_o);
  assert_cap_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && flag_o) |=> $stable(cap_o));
  assert_pri_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd3) |=> $stable(pri_idx_o));
  assert_irq_match_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_only_i && !match) |=> !irq_o);
endmodule

// File: tb/tb_pattern_match_detector.sv
module tb_pattern_match_detector;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] data_i, inv_i, mask_i, trans_i, pol_i;
  logic [1:0] mode_i;
  logic       latch_en_i, match_only_i, clr_i;
  logic       flag_o, irq_o;
  logic [7:0] cap_o;
  logic [2:0] pri_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pattern_match_detector dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .inv_i(inv_i),
    .mask_i(mask_i), .trans_i(trans_i), .pol_i(pol_i), .mode_i(mode_i),
    .latch_en_i(latch_en_i), .match_only_i(match_only_i), .clr_i(clr_i),
    .flag_o(flag_o), .irq_o(irq_o), .cap_o(cap_o), .pri_idx_o(pri_idx_o)
  );

  typedef struct packed {
    logic [7:0] inv, mask, trans, pol;
    logic [1:0] mode;
    logic [7:0] d0, d1;
    logic       flg;
    logic [2:0] vec;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{8'h00, 8'h00, 8'h00, 8'h00, 2'd2, 8'h00, 8'hFF, 1'b0, 3'd0}, // R1 ignored
    '{8'h00, 8'h00, 8'h01, 8'h00, 2'd2, 8'h00, 8'h01, 1'b1, 3'd0}, // R2 rise
    '{8'h00, 8'h00, 8'h01, 8'h00, 2'd2, 8'h01, 8'h00, 1'b1, 3'd0}, // R2 fall
    '{8'h00, 8'h04, 8'h00, 8'h04, 2'd2, 8'h00, 8'h04, 1'b1, 3'd0}, // R3 high
    '{8'h00, 8'h04, 8'h00, 8'h00, 2'd2, 8'h04, 8'h04, 1'b0, 3'd0}, // R3 low miss
    '{8'h00, 8'h10, 8'h10, 8'h10, 2'd2, 8'h00, 8'h10, 1'b1, 3'd0}, // R4 rising
    '{8'h00, 8'h10, 8'h10, 8'h10, 2'd2, 8'h10, 8'h10, 1'b0, 3'd0}, // R4 steady
    '{8'h00, 8'h10, 8'h10, 8'h00, 2'd2, 8'h10, 8'h00, 1'b1, 3'd0}, // R4 falling
    '{8'h00, 8'h03, 8'h00, 8'h03, 2'd1, 8'h00, 8'h03, 1'b1, 3'd0}, // R6 AND all
    '{8'h00, 8'h03, 8'h00, 8'h03, 2'd1, 8'h00, 8'h01, 1'b0, 3'd0}, // R6 AND part
    '{8'h00, 8'h00, 8'h00, 8'h00, 2'd1, 8'h00, 8'hFF, 1'b0, 3'd0}, // R6 AND empty
    '{8'h00, 8'h03, 8'h00, 8'h03, 2'd0, 8'h00, 8'h03, 1'b0, 3'd0}, // R6 off
    '{8'h01, 8'h01, 8'h00, 8'h01, 2'd2, 8'h00, 8'h00, 1'b1, 3'd0}, // R5 inverted hit
    '{8'h01, 8'h01, 8'h00, 8'h01, 2'd2, 8'h00, 8'h01, 1'b0, 3'd0}, // R5 inverted miss
    '{8'h00, 8'hA4, 8'h00, 8'hA4, 2'd3, 8'h00, 8'hA4, 1'b1, 3'd7}, // R7
    '{8'h00, 8'h2C, 8'h00, 8'h2C, 2'd3, 8'h00, 8'h0C, 1'b1, 3'd3}, // R7
    '{8'h00, 8'h01, 8'h02, 8'h01, 2'd3, 8'h00, 8'h03, 1'b1, 3'd1}  // R7 mixed
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cfg(input logic [7:0] iv, mk, tr, pl, input logic [1:0] md);
    inv_i = iv; mask_i = mk; trans_i = tr; pol_i = pl; mode_i = md;
  endtask

  // disable matching, clear flag, settle history on d
  task automatic flush(input logic [7:0] d);
    logic [1:0] keep;
    keep = mode_i;
    mode_i = 2'd0; clr_i = 1'b1; data_i = d;
    tick();
    clr_i = 1'b0; mode_i = keep;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    data_i = 8'h01; clr_i = 1'b0; latch_en_i = 1'b1; match_only_i = 1'b1;
    cfg(8'h00, 8'h01, 8'h01, 8'h01, 2'd2);
    @(negedge clk_i); @(negedge clk_i);
    chk("R11 flag", flag_o, 0);
    chk("R11 irq", irq_o, 0);
    chk("R11 cap", cap_o, 0);
    chk("R11 pri_idx", pri_idx_o, 0);
    rst_ni = 1'b1;
    tick();
    chk("R4 no edge after reset", flag_o, 0);
    tick();
    chk("R4 steady after reset", flag_o, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      cfg(TBL[k].inv, TBL[k].mask, TBL[k].trans, TBL[k].pol, TBL[k].mode);
      flush(TBL[k].d0);
      data_i = TBL[k].d1;
      tick();
      chk($sformatf("R1-6 table %0d flag", k), flag_o, TBL[k].flg);
      chk($sformatf("R10 table %0d irq", k), irq_o, TBL[k].flg);
      if (TBL[k].flg)
        chk($sformatf("R9 table %0d cap", k), cap_o, TBL[k].d1 ^ TBL[k].inv);
      if (TBL[k].mode == 2'd3)
        chk($sformatf("R7 table %0d pri_idx", k), pri_idx_o, TBL[k].vec);
    end

    // R8 sticky flag, clear, set beats clear
    cfg(8'h00, 8'h01, 8'h00, 8'h01, 2'd2);
    flush(8'h00);
    data_i = 8'h01; tick();
    chk("R8 set", flag_o, 1);
    data_i = 8'h00; tick(); tick();
    chk("R8 sticky", flag_o, 1);
    clr_i = 1'b1; tick();
    chk("R8 cleared", flag_o, 0);
    data_i = 8'h01; tick();
    chk("R8 set beats clear", flag_o, 1);
    clr_i = 1'b0;

    // R9 capture freeze and tracking
    flush(8'h00);
    data_i = 8'h41; tick();
    chk("R9 capture", cap_o, 8'h41);
    data_i = 8'h81; tick();
    chk("R9 frozen", cap_o, 8'h41);
    latch_en_i = 1'b0; data_i = 8'h22; tick();
    chk("R9 tracking", cap_o, 8'h22);
    latch_en_i = 1'b1;

    // R10 change interrupts
    cfg(8'h00, 8'h00, 8'h00, 8'h00, 2'd0);
    match_only_i = 1'b0;
    flush(8'h00);
    data_i = 8'h10; tick();
    chk("R10 change irq", irq_o, 1);
    tick();
    chk("R10 no change", irq_o, 0);
    match_only_i = 1'b1; data_i = 8'h20; tick();
    chk("R10 match only", irq_o, 0);

    // R7 index held outside priority mode
    cfg(8'h00, 8'h08, 8'h00, 8'h08, 2'd3);
    flush(8'h00);
    data_i = 8'h08; tick();
    chk("R7 capture idx", pri_idx_o, 3);
    cfg(8'h00, 8'h80, 8'h00, 8'h80, 2'd2);
    flush(8'h00);
    data_i = 8'h80; tick();
    chk("R7 or flag", flag_o, 1);
    chk("R7 idx held", pri_idx_o, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule